// File: doc/BRIEF.md
# Sequencer Gate Pulse Generator

This block produces the gate output of a step sequencer. It is clocked by the core clock but does work only on a one-cycle tick strobe. On each tick it takes the current phase accumulator value, a run flag, the current step index, a base gate length, a signed length modulation and a retrigger request. From these it decides whether the gate is high for the coming tick. In normal running the gate stays high while the phase, scaled down by a fixed right shift, has not passed the effective gate length. The effective length is base plus modulation, clamped to a fixed window. A larger length therefore gives a longer gate within each step period.

Two corner cases override the normal comparison. After the sequencer stops and then runs again, the gate stays low until the step index moves on. This keeps a half-finished step from sounding again on resume. A retrigger request, which arrives with an immediate sequence reset, forces the gate low for exactly one running tick. This gives a fresh rising edge even when the gate was already high. The phase accumulator, step counting and clock selection sit outside this block.

Top module: `seq_gate_gen`

## Requirements
- R1: A synchronous reset drives the gate low and clears the hold-after-resume state, any pending retrigger and the stored step. The first running tick after reset therefore follows the normal comparison.
- R2: The effective length is base + modulation, formed without overflow from two signed 32-bit values, and capped at 2^27. A sum at or above 2^27 - 1 keeps the gate high for every 32-bit phase. A sum of 2^27 - 5 puts the gate low at phase 0xFFFFFFFF.
- R3: A negative sum, including one whose 32-bit wrap would look positive, clamps to 0. The gate is then high only while phase >> 5 equals 0 (phase 31 high, phase 32 low).
- R4: On a running tick with no hold and no retrigger, the gate goes high when (phase >> 5) <= effective length and low otherwise. This is visible on the output one clock after the tick edge.
- R5: A tick with run low drives the gate low and arms the hold-after-resume state.
- R6: While the hold is armed, running ticks keep the gate low. The hold releases on the first running tick whose step index differs from the step seen on the last running tick. That tick still gives a low gate, and the following tick follows R4.
- R7: A retrigger request on a running tick with no hold active gives a low gate for that one tick. The next tick follows R4.
- R8: The hold takes priority over a retrigger. A retrigger requested during the hold stays pending and produces its single low tick on the first running tick after the hold releases.
- R9: Cycles without a tick leave the gate unchanged whatever the other inputs do, and a retrigger request given without a tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Control-rate strobe; all state updates happen on it |
| run | input | 1 | Sequencer running flag |
| step_idx | input | STEP_W (8) | Current step index |
| phase | input | PHASE_W (32) | Phase accumulator value |
| len_base | input | LEN_W (32) | Base gate length, signed |
| len_mod | input | LEN_W (32) | Gate length modulation, signed |
| retrig_req | input | 1 | Retrigger request from an immediate reset |
| gate | output | 1 | Gate output |

## Verification
The hold after resume and a retrigger request can land on the same running tick. The bench provokes this by stopping the sequencer, then resuming with the request raised on the first running tick at an unchanged step. The gate must stay low through the hold. The step must then advance, and the pending request must show as one more low tick after the release tick. Only after that does the gate return high under the phase comparison. Each tick's expected gate level is queued by hand from the requirements and compared one clock later.

// File: rtl/seq_gate_pkg.sv
package seq_gate_pkg;
   // Which rule decides the gate on a tick
   typedef enum logic [1:0] {
      GSRC_STOP = 2'd0,
      GSRC_HOLD = 2'd1,
      GSRC_RTRG = 2'd2,
      GSRC_CMP  = 2'd3
   } gate_src_e;
endpackage

// File: rtl/seq_gate_len.sv
// Effective gate length: signed sum with one guard bit, then clamp to [0, 2^CAP_LOG2]
module seq_gate_len #(
   parameter int LEN_W    = 32,
   parameter int CAP_LOG2 = 27,
   localparam int OUT_W   = CAP_LOG2 + 1
) (
   input  logic signed [LEN_W-1:0] len_base,
   input  logic signed [LEN_W-1:0] len_mod,
   output logic        [OUT_W-1:0] len_eff
);
   logic signed [LEN_W:0] sum_ext;
   logic signed [LEN_W:0] cap_ext;

   assign cap_ext = {{(LEN_W-CAP_LOG2){1'b0}}, 1'b1, {CAP_LOG2{1'b0}}};
   assign sum_ext = {len_base[LEN_W-1], len_base} + {len_mod[LEN_W-1], len_mod};

   always_comb begin
      if (sum_ext < 0)
         len_eff = '0;
      else if (sum_ext > cap_ext)
         len_eff = cap_ext[OUT_W-1:0];
      else
         len_eff = sum_ext[OUT_W-1:0];
   end
endmodule

// File: rtl/seq_gate_cmp.sv
// Scaled phase compare: over = (phase >> SHIFT) > len
module seq_gate_cmp #(
   parameter int PHASE_W = 32,
   parameter int SHIFT   = 5,
   parameter int LEN_OW  = 28,
   localparam int CW     = (PHASE_W > LEN_OW) ? PHASE_W : LEN_OW
) (
   input  logic [PHASE_W-1:0] phase,
   input  logic [LEN_OW-1:0]  len_eff,
   output logic               over
);
   logic [CW-1:0] phase_scaled;

   generate
      if (SHIFT == 0) begin : g_noshift
         assign phase_scaled = CW'(phase);
      end else begin : g_shift
         assign phase_scaled = CW'(phase) >> SHIFT;
      end
   endgenerate

   assign over = phase_scaled > CW'(len_eff);
endmodule

// File: rtl/seq_gate_ctl.sv
// Gate register with resume-hold and one-tick retrigger handling
module seq_gate_ctl
   import seq_gate_pkg::*;
#(
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              run,
   input  logic [STEP_W-1:0] step_idx,
   input  logic              retrig_req,
   input  logic              over,
   output logic              gate,
   output logic              hold_q,
   output logic              rtrg_q
);
   logic [STEP_W-1:0] prev_step_q;
   gate_src_e         src;
   logic              rtrg_any;

   assign rtrg_any = rtrg_q | retrig_req;

   always_comb begin
      if (!run)
         src = GSRC_STOP;
      else if (hold_q)
         src = GSRC_HOLD;
      else if (rtrg_any)
         src = GSRC_RTRG;
      else
         src = GSRC_CMP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gate        <= 1'b0;
         hold_q      <= 1'b0;
         rtrg_q      <= 1'b0;
         prev_step_q <= '0;
      end else if (tick) begin
         unique case (src)
            GSRC_STOP: begin
               gate   <= 1'b0;
               hold_q <= 1'b1;
               rtrg_q <= rtrg_any;
            end
            GSRC_HOLD: begin
               gate        <= 1'b0;
               rtrg_q      <= rtrg_any;
               prev_step_q <= step_idx;
               if (step_idx != prev_step_q)
                  hold_q <= 1'b0;
            end
            GSRC_RTRG: begin
               gate        <= 1'b0;
               rtrg_q      <= 1'b0;
               prev_step_q <= step_idx;
            end
            default: begin
               gate        <= ~over;
               prev_step_q <= step_idx;
            end
         endcase
      end
   end
endmodule

// File: rtl/seq_gate_gen.sv
module seq_gate_gen #(
   parameter int PHASE_W     = 32,
   parameter int STEP_W      = 8,
   parameter int LEN_W       = 32,
   parameter int CAP_LOG2    = 27,
   parameter int PHASE_SHIFT = 5,
   localparam int LEN_OW     = CAP_LOG2 + 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic               run,
   input  logic [STEP_W-1:0]  step_idx,
   input  logic [PHASE_W-1:0] phase,
   input  logic [LEN_W-1:0]   len_base,
   input  logic [LEN_W-1:0]   len_mod,
   input  logic               retrig_req,
   output logic               gate
);
   generate
      if (PHASE_SHIFT < 0 || PHASE_SHIFT >= PHASE_W) begin : g_bad_shift
         $error("PHASE_SHIFT must lie in [0, PHASE_W)");
      end
      if (CAP_LOG2 < 1 || CAP_LOG2 > LEN_W - 2) begin : g_bad_cap
         $error("CAP_LOG2 must lie in [1, LEN_W-2]");
      end
      if (STEP_W < 1) begin : g_bad_step
         $error("STEP_W must be positive");
      end
   endgenerate

   logic [LEN_OW-1:0] len_eff;
   logic              over;
   logic              hold_q;
   logic              rtrg_q;

   seq_gate_len #(.LEN_W(LEN_W), .CAP_LOG2(CAP_LOG2)) u_len (
      .len_base (len_base),
      .len_mod  (len_mod),
      .len_eff  (len_eff)
   );

   seq_gate_cmp #(.PHASE_W(PHASE_W), .SHIFT(PHASE_SHIFT), .LEN_OW(LEN_OW)) u_cmp (
      .phase   (phase),
      .len_eff (len_eff),
      .over    (over)
   );

   seq_gate_ctl #(.STEP_W(STEP_W)) u_ctl (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .run        (run),
      .step_idx   (step_idx),
      .retrig_req (retrig_req),
      .over       (over),
      .gate       (gate),
      .hold_q     (hold_q),
      .rtrg_q     (rtrg_q)
   );
endmodule

// File: rtl/seq_gate_chk.sv
module seq_gate_chk #(
   parameter int PHASE_W     = 32,
   parameter int CAP_LOG2    = 27,
   parameter int PHASE_SHIFT = 5,
   localparam int LEN_OW     = CAP_LOG2 + 1,
   localparam int CW         = (PHASE_W > LEN_OW) ? PHASE_W : LEN_OW
) (
   input logic               clk,
   input logic               rst,
   input logic               tick,
   input logic               run,
   input logic               retrig_req,
   input logic [PHASE_W-1:0] phase,
   input logic [LEN_OW-1:0]  len_eff,
   input logic               hold_q,
   input logic               rtrg_q,
   input logic               gate
);
   logic [LEN_OW-1:0] cap_val;
   logic [CW-1:0]     ph_sc;
   assign cap_val = {1'b1, {CAP_LOG2{1'b0}}};
   assign ph_sc   = CW'(phase) >> PHASE_SHIFT;

   assert_reset_low_R1: assert property (@(posedge clk) rst |=> !gate && !hold_q && !rtrg_q);

   assert_len_cap_R2: assert property (@(posedge clk) disable iff (rst) len_eff <= cap_val);

   assert_cmp_low_R4: assert property (@(posedge clk) disable iff (rst)
      tick && run && !hold_q && !rtrg_q && !retrig_req && (ph_sc > CW'(len_eff)) |=> !gate);

   assert_stop_low_R5: assert property (@(posedge clk) disable iff (rst)
      tick && !run |=> !gate && hold_q);

   assert_hold_low_R6: assert property (@(posedge clk) disable iff (rst)
      tick && run && hold_q |=> !gate);

   assert_rtrg_once_R7: assert property (@(posedge clk) disable iff (rst)
      tick && run && !hold_q && (rtrg_q || retrig_req) |=> !gate && !rtrg_q);

   assert_hold_first_R8: assert property (@(posedge clk) disable iff (rst)
      tick && run && hold_q && retrig_req |=> rtrg_q);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(gate) && $stable(hold_q) && $stable(rtrg_q));
endmodule

bind seq_gate_gen seq_gate_chk #(
   .PHASE_W     (PHASE_W),
   .CAP_LOG2    (CAP_LOG2),
   .PHASE_SHIFT (PHASE_SHIFT)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .tick       (tick),
   .run        (run),
   .retrig_req (retrig_req),
   .phase      (phase),
   .len_eff    (len_eff),
   .hold_q     (hold_q),
   .rtrg_q     (rtrg_q),
   .gate       (gate)
);

// File: tb/tb_seq_gate_gen.sv
`timescale 1ns/1ps
module tb_seq_gate_gen;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick = 1'b0;
   logic        run = 1'b0;
   logic [7:0]  step_idx = '0;
   logic [31:0] phase = '0;
   logic [31:0] len_base = '0;
   logic [31:0] len_mod = '0;
   logic        retrig_req = 1'b0;
   logic        gate;

   always #10 clk = ~clk;

   seq_gate_gen dut (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .run        (run),
      .step_idx   (step_idx),
      .phase      (phase),
      .len_base   (len_base),
      .len_mod    (len_mod),
      .retrig_req (retrig_req),
      .gate       (gate)
   );

   typedef struct {
      logic  exp;
      string tag;
   } item_t;

   item_t q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   logic  drv_valid = 1'b0;
   logic  armed = 1'b0;
   bit    done = 1'b0;

   always @(posedge clk) armed <= drv_valid;

   // Monitor: one clock after each driven cycle, compare against the queue head
   always @(negedge clk) begin
      if (armed && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_vec++;
         if (gate !== it.exp) begin
            n_bad++;
            $display("FAIL %s: gate=%0b expected %0b (vector %0d)", it.tag, gate, it.exp, n_vec);
         end
      end
   end

   task automatic drv(input bit r, input bit tk, input bit rn, input int s,
                      input logic [31:0] ph, input int b, input int m,
                      input bit e, input bit ex, input string tag);
      item_t it;
      @(negedge clk);
      rst        = r;
      tick       = tk;
      run        = rn;
      step_idx   = 8'(s);
      phase      = ph;
      len_base   = b;
      len_mod    = m;
      retrig_req = e;
      drv_valid  = 1'b1;
      it.exp     = ex;
      it.tag     = tag;
      q.push_back(it);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset holds gate low even with a ticking, running, in-range phase
      drv(1, 1, 1, 0, 0, 1000, 0, 0, 0, "R1");
      drv(1, 1, 1, 0, 0, 1000, 0, 0, 0, "R1");
      // R1/R4: first running tick after reset uses the comparison directly
      drv(0, 1, 1, 2, 0, 1000, 0, 0, 1, "R1");
      // R4: boundary around length 1000 (phase 32000 -> 1000, 32032 -> 1001)
      drv(0, 1, 1, 2, 32000, 1000, 0, 0, 1, "R4");
      drv(0, 1, 1, 2, 32032, 1000, 0, 0, 0, "R4");
      drv(0, 1, 1, 2, 32000, 900, 100, 0, 1, "R4");
      drv(0, 1, 1, 2, 32032, 900, 101, 0, 1, "R4");
      // R2: overflow-free sum, cap, and just below the top scaled phase
      drv(0, 1, 1, 2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, "R2");
      drv(0, 1, 1, 2, 32'hFFFF_FFFF, (1 << 27) + 50, 0, 0, 1, "R2");
      drv(0, 1, 1, 2, 32'hFFFF_FFFF, (1 << 27) - 1, 0, 0, 1, "R2");
      drv(0, 1, 1, 2, 32'hFFFF_FFFF, (1 << 27) + 5, -10, 0, 0, "R2");
      // R3: negative sums clamp to zero
      drv(0, 1, 1, 2, 31, 10, -100, 0, 1, "R3");
      drv(0, 1, 1, 2, 32, 10, -100, 0, 0, "R3");
      drv(0, 1, 1, 2, 32, 32'h8000_0000, -1, 0, 0, "R3");
      // R9: gate high, then non-tick cycles with hostile inputs leave it alone
      drv(0, 1, 1, 2, 0, 1000, 0, 0, 1, "R4");
      drv(0, 0, 0, 2, 32'hFFFF_FFFF, 0, -5, 1, 1, "R9");
      drv(0, 0, 0, 5, 32'hFFFF_FFFF, 0, -5, 1, 1, "R9");
      drv(0, 0, 1, 2, 32'hFFFF_FFFF, 0, -5, 1, 1, "R9");
      // R9: the retrigger seen without a tick left nothing pending
      drv(0, 1, 1, 2, 0, 1000, 0, 0, 1, "R9");
      // R5: stop ticks
      drv(0, 1, 0, 2, 0, 1000, 0, 0, 0, "R5");
      drv(0, 1, 0, 2, 0, 1000, 0, 0, 0, "R5");
      // R6: resume on same step held low, release tick low, then normal
      drv(0, 1, 1, 2, 0, 1000, 0, 0, 0, "R6");
      drv(0, 1, 1, 2, 0, 1000, 0, 0, 0, "R6");
      drv(0, 1, 1, 3, 0, 1000, 0, 0, 0, "R6");
      drv(0, 1, 1, 3, 0, 1000, 0, 0, 1, "R6");
      // R7: single low tick on retrigger
      drv(0, 1, 1, 3, 0, 1000, 0, 1, 0, "R7");
      drv(0, 1, 1, 3, 0, 1000, 0, 0, 1, "R7");
      // R8: hold and retrigger on the same tick
      drv(0, 1, 0, 3, 0, 1000, 0, 0, 0, "R5");
      drv(0, 1, 1, 3, 0, 1000, 0, 1, 0, "R8");
      drv(0, 1, 1, 3, 0, 1000, 0, 0, 0, "R8");
      drv(0, 1, 1, 4, 0, 1000, 0, 0, 0, "R8");
      drv(0, 1, 1, 4, 0, 1000, 0, 0, 0, "R8");
      drv(0, 1, 1, 4, 0, 1000, 0, 0, 1, "R8");
      // R1: arm hold and a pending retrigger, then reset clears both
      drv(0, 1, 0, 4, 0, 1000, 0, 1, 0, "R5");
      drv(1, 0, 0, 4, 0, 1000, 0, 0, 0, "R1");
      drv(0, 1, 1, 4, 0, 1000, 0, 0, 1, "R1");
      drv(0, 1, 1, 4, 0, 1000, 0, 0, 1, "R1");
      @(negedge clk);
      drv_valid = 1'b0;
      tick      = 1'b0;
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule